// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Arbiter

This block arbitrates a row of interrupting devices that share one request line and one vector bus. Each device turns a rising edge on its request input into a pending flag. All pending flags are ORed onto a single request output for the core. When the core raises its acknowledge, the acknowledge goes into device 0, which sits nearest the core and has the highest priority. It then ripples outward. A device that is not pending passes the acknowledge on. The first pending device keeps it, and only that device drives its vector onto the shared bus. Every device farther out sees no acknowledge and stays pending.

The bus is built from one-hot per-device drive enables and an AND-OR mux, standing in for tri-state drivers. While acknowledge is high, the chain is frozen. Request edges that arrive during that time are held and join the pending set once acknowledge drops. This keeps a higher-priority newcomer from taking the bus in the middle of a cycle. The serviced device drops its pending flag on the clock edge that first sees its received acknowledge low.

Top module: `daisy_ack_arbiter`

## Requirements
- R1: After reset, irqOut is 0, busValid is 0, busData is 0 and winner is 0.
- R2: A rising edge on reqEvent[i], sampled at a clock edge while ackIn is low, makes device i pending from that edge onward. A one-cycle pulse is enough. irqOut is the OR of all pending flags.
- R3: A request held high counts once. After it has been serviced, it does not become pending again until it goes low and then high again.
- R4: While ackIn is high, winner is one-hot on the lowest-index pending device. Bit i of winner stands for device i, and index 0 has the highest priority.
- R5: While ackIn is high and some device is pending, busValid is 1 and busData equals that device's vector, vecIn[i*VEC_W +: VEC_W]. Both appear in the same cycle as ackIn, with no register in the path.
- R6: Devices beyond the winner receive no acknowledge. They keep their pending flags, so irqOut stays 1 after the winner is serviced.
- R7: If no device is pending while ackIn is high, busValid is 0, busData is 0 and winner is 0.
- R8: The winning device clears its pending flag at the first clock edge where its received acknowledge is low after having been high.
- R9: A request edge that arrives while ackIn is high leaves winner, busData and irqOut unchanged during that acknowledge. It becomes pending at the first clock edge with ackIn low.
- R10: At most one bit of winner, which is the set of per-device drive enables, is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqEvent | input | NUM_DEV | Per-device request inputs, edge detected |
| vecIn | input | NUM_DEV*VEC_W | Per-device vectors, device i in slice i |
| ackIn | input | 1 | Acknowledge from the core, entering at device 0 |
| irqOut | output | 1 | Wired-OR of all pending requests |
| busData | output | VEC_W | Shared vector bus, 0 when not driven |
| busValid | output | 1 | A device is driving busData |
| winner | output | NUM_DEV | One-hot drive enable of the device that stopped the acknowledge |

## Verification
A pending flag that is lost or stuck shows up at once. irqOut is wrong in the cycle after the edge. The next acknowledge then picks the wrong winner and vector in the same cycle that ackIn rises. A flag that fails to clear shows up as the same device winning the following acknowledge. A broken hold of request edges during acknowledge shows up as a winner or bus change inside a single acknowledge window, or as a request that never reaches irqOut after ackIn falls. Random request and acknowledge traffic, compared every cycle, exposes these faults within a few cycles of the fault.

// File: rtl/daisy_ack_pkg.sv
package daisy_ack_pkg;
  typedef struct packed {
    logic holdEvents;  // acknowledge active: defer new request edges
    logic busEnable;   // some device drives the bus this cycle
  } chainStrobes_t;
endpackage

// File: rtl/daisy_ack_datapath.sv
module daisy_ack_datapath
  import daisy_ack_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int VEC_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_DEV-1:0]       reqEvent,
  input  logic [NUM_DEV*VEC_W-1:0] vecIn,
  input  chainStrobes_t            strobes,
  input  logic [NUM_DEV-1:0]       clearMask,
  input  logic [NUM_DEV-1:0]       driveEn,
  output logic [NUM_DEV-1:0]       pending,
  output logic [VEC_W-1:0]         busData
);
  logic [NUM_DEV-1:0] reqPrev;
  logic [NUM_DEV-1:0] caught;
  logic [NUM_DEV-1:0] seen;

  assign seen = reqEvent & ~reqPrev;

  for (genvar g = 0; g < NUM_DEV; g++) begin : gDev
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reqPrev[g] <= 1'b0;
        caught[g]  <= 1'b0;
        pending[g] <= 1'b0;
      end else begin
        reqPrev[g] <= reqEvent[g];
        if (strobes.holdEvents) begin
          caught[g] <= caught[g] | seen[g];
        end else begin
          caught[g]  <= 1'b0;
          pending[g] <= (pending[g] & ~clearMask[g]) | seen[g] | caught[g];
        end
      end
    end
  end

  always_comb begin
    busData = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (driveEn[i] && strobes.busEnable) busData = busData | vecIn[i*VEC_W +: VEC_W];
    end
  end
endmodule

// File: rtl/daisy_ack_control.sv
module daisy_ack_control
  import daisy_ack_pkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ackIn,
  input  logic [NUM_DEV-1:0] pending,
  output chainStrobes_t      strobes,
  output logic [NUM_DEV-1:0] clearMask,
  output logic [NUM_DEV-1:0] driveEn
);
  logic [NUM_DEV:0]   passIn;
  logic [NUM_DEV-1:0] recvPrev;

  always_comb begin
    passIn[0] = ackIn;
    for (int i = 0; i < NUM_DEV; i++) begin
      driveEn[i]  = passIn[i] & pending[i];
      passIn[i+1] = passIn[i] & ~pending[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) recvPrev <= '0;
    else        recvPrev <= passIn[NUM_DEV-1:0];
  end

  assign clearMask          = recvPrev & ~passIn[NUM_DEV-1:0];
  assign strobes.holdEvents = ackIn;
  assign strobes.busEnable  = |driveEn;
endmodule

// File: rtl/daisy_ack_arbiter.sv
module daisy_ack_arbiter
  import daisy_ack_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int VEC_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_DEV-1:0]       reqEvent,
  input  logic [NUM_DEV*VEC_W-1:0] vecIn,
  input  logic                     ackIn,
  output logic                     irqOut,
  output logic [VEC_W-1:0]         busData,
  output logic                     busValid,
  output logic [NUM_DEV-1:0]       winner
);
  chainStrobes_t      strobes;
  logic [NUM_DEV-1:0] clearMask;
  logic [NUM_DEV-1:0] driveEn;
  logic [NUM_DEV-1:0] pending;

  daisy_ack_control #(.NUM_DEV(NUM_DEV)) i_ctl (
    .clk(clk), .rst_n(rst_n), .ackIn(ackIn), .pending(pending),
    .strobes(strobes), .clearMask(clearMask), .driveEn(driveEn)
  );

  daisy_ack_datapath #(.NUM_DEV(NUM_DEV), .VEC_W(VEC_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .reqEvent(reqEvent), .vecIn(vecIn),
    .strobes(strobes), .clearMask(clearMask), .driveEn(driveEn),
    .pending(pending), .busData(busData)
  );

  assign irqOut   = |pending;
  assign busValid = strobes.busEnable;
  assign winner   = driveEn;
endmodule

// File: rtl/daisy_ack_checker.sv
module daisy_ack_checker #(
  parameter int NUM_DEV = 4,
  parameter int VEC_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ackIn,
  input logic               irqOut,
  input logic [VEC_W-1:0]   busData,
  input logic               busValid,
  input logic [NUM_DEV-1:0] winner
);
  a_r10_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(winner));
  a_r7_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !busValid |-> (busData == '0 && winner == '0));
  a_r5_drive_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    busValid |-> (ackIn && irqOut));
  a_r9_winner_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ackIn && $past(ackIn)) |-> $stable(winner));
  a_r9_irq_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ackIn && $past(ackIn)) |-> $stable(irqOut));
endmodule

bind daisy_ack_arbiter daisy_ack_checker #(.NUM_DEV(NUM_DEV), .VEC_W(VEC_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .ackIn(ackIn), .irqOut(irqOut),
  .busData(busData), .busValid(busValid), .winner(winner)
);

// File: tb/test_daisy_ack_arbiter.sv
`timescale 1ns/1ps
module test_daisy_ack_arbiter;
  localparam int N = 4;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] reqEvent = '0;
  logic [N*W-1:0] vecIn;
  logic ackIn = 1'b0;
  logic irqOut, busValid;
  logic [W-1:0] busData;
  logic [N-1:0] winner;

  int checks = 0;
  int fails = 0;

  // bench model state
  logic [N-1:0] mPend = '0, mCaught = '0, mRecvPrev = '0, mPrevEv = '0;

  always #10 clk = ~clk;

  daisy_ack_arbiter #(.NUM_DEV(N), .VEC_W(W)) i_daisy_ack_arbiter (
    .clk(clk), .rst_n(rst_n), .reqEvent(reqEvent), .vecIn(vecIn), .ackIn(ackIn),
    .irqOut(irqOut), .busData(busData), .busValid(busValid), .winner(winner)
  );

  function automatic logic [N-1:0] recvOf(logic [N-1:0] p, logic a);
    logic [N-1:0] r;
    logic live;
    live = a;
    for (int i = 0; i < N; i++) begin
      r[i] = live;
      live = live & ~p[i];
    end
    return r;
  endfunction

  function automatic logic [N-1:0] expWin(logic [N-1:0] p, logic a);
    return recvOf(p, a) & p;
  endfunction

  function automatic logic [W-1:0] expBus(logic [N-1:0] p, logic a);
    logic [N-1:0] w;
    w = expWin(p, a);
    for (int i = 0; i < N; i++) if (w[i]) return vecIn[i*W +: W];
    return '0;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    logic [N-1:0] w;
    w = expWin(mPend, ackIn);
    check(req, "irqOut", 32'(irqOut), 32'(|mPend));
    check(req, "winner", 32'(winner), 32'(w));
    check(req, "busValid", 32'(busValid), 32'(|w));
    check(req, "busData", 32'(busData), 32'(expBus(mPend, ackIn)));
  endtask

  // apply inputs at negedge, check outputs, then advance the model over one posedge
  task automatic step(logic [N-1:0] ev, logic a, string req);
    logic [N-1:0] seen, recvNow, fall;
    reqEvent = ev;
    ackIn = a;
    #1;
    checkAll(req);
    @(posedge clk);
    seen = ev & ~mPrevEv;
    recvNow = recvOf(mPend, a);
    fall = mRecvPrev & ~recvNow;
    if (a) mCaught = mCaught | seen;
    else begin
      mPend = (mPend & ~fall) | seen | mCaught;
      mCaught = '0;
    end
    mRecvPrev = recvNow;
    mPrevEv = ev;
    @(negedge clk);
  endtask

  initial begin
    #(20.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < N; i++) vecIn[i*W +: W] = W'(8'h40 + 8'(i * 17));
    @(negedge clk);
    #1;
    // R1 reset state
    check("R1", "irqOut", 32'(irqOut), 0);
    check("R1", "busValid", 32'(busValid), 0);
    check("R1", "busData", 32'(busData), 0);
    check("R1", "winner", 32'(winner), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 ack with nothing pending
    step(4'b0000, 1'b1, "R7");
    step(4'b0000, 1'b0, "R7");
    // R2 single-cycle pulses on devices 2 and 3
    step(4'b1100, 1'b0, "R2");
    step(4'b0000, 1'b0, "R2");
    check("R2", "irqOut after pulse", 32'(irqOut), 1);
    // R4 R5 R6 device 2 wins, device 3 stays pending
    step(4'b0000, 1'b1, "R4");
    check("R5", "vector of device 2", 32'(busData), 32'(vecIn[2*W +: W]));
    step(4'b0000, 1'b1, "R5");
    step(4'b0000, 1'b0, "R8");
    step(4'b0000, 1'b1, "R6");
    check("R6", "device 3 wins next", 32'(winner), 32'(4'b1000));
    step(4'b0000, 1'b0, "R8");
    step(4'b0000, 1'b0, "R8");
    check("R8", "all serviced", 32'(irqOut), 0);
    // R9 device 1 pending, device 0 edge during ack is deferred
    step(4'b0010, 1'b0, "R2");
    step(4'b0010, 1'b1, "R9");
    step(4'b0011, 1'b1, "R9");
    check("R9", "winner held on device 1", 32'(winner), 32'(4'b0010));
    step(4'b0011, 1'b0, "R9");
    check("R9", "deferred edge now pending", 32'(irqOut), 1);
    step(4'b0011, 1'b1, "R9");
    check("R9", "device 0 wins after ack", 32'(winner), 32'(4'b0001));
    step(4'b0011, 1'b0, "R3");
    step(4'b0011, 1'b0, "R3");
    // R3 held-high inputs do not re-request
    check("R3", "no re-request while held", 32'(irqOut), 0);
    step(4'b0000, 1'b0, "R3");
    step(4'b0001, 1'b0, "R3");
    check("R3", "new edge after low", 32'(irqOut), 1);
    step(4'b0001, 1'b1, "R4");
    step(4'b0000, 1'b0, "R8");

    // R10 random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] ev;
      logic a;
      ev = N'($urandom % 16) & N'($urandom % 16);
      a = ($urandom % 3) == 0;
      if (k % 97 == 0) for (int i = 0; i < N; i++) vecIn[i*W +: W] = W'($urandom);
      step(ev, a, "R10");
      check("R10", "one-hot winner", 32'($countones(winner) <= 1), 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule